// File: doc/BRIEF.md
# Shape-Selectable Two-Clock 4-kbit RAM

This block is a 4096-bit synchronous memory with one write port and one read port. Each port runs on its own clock. A static shape parameter picks how the fixed store is seen from the ports: 256 words of 16 bits, 512 of 8, 1024 of 4 or 2048 of 2. The port widths follow from that choice.

Every shape addresses the same physical bits. Word `A` of a `W`-bit shape covers store bits `A*W` up to `A*W+W-1`, so an initial-content vector means the same thing in every shape. In the 16-bit shape the write port honours a per-bit write mask. In the narrower shapes a single enable writes the whole word and the mask input is ignored.

The read port returns data through an output register that loads only when its enable is high. There is no bypass from the write port: a read of a word that is written on the same edge returns the stored value from before that write. Each port samples on the rising or the falling edge of its clock, chosen by its own parameter. Each clock domain has its own synchronous active-high reset.

Top module: `ar_ram4k`

## Requirements
- R1: While `rd_rst` is high at an active read edge, `rd_data` becomes all zeros at that edge, whatever the value of `rd_en`.
- R2: The `ASPECT` parameter selects the shape. 0 is 256x16 with an 8-bit address, 1 is 512x8 with 9 bits, 2 is 1024x4 with 10 bits and 3 is 2048x2 with 11 bits. Word `A` of width `W` reads store bits `[A*W +: W]`, and after configuration these hold `INIT_BITS[A*W +: W]`.
- R3: In shape 0, a write with `wr_en` high changes bit `i` of the addressed word only when `wr_mask[i]` is 1. The other bits keep their old value.
- R4: In shapes 1 to 3, a write with `wr_en` high replaces the whole addressed word, and `wr_mask` has no effect.
- R5: At an active write edge where `wr_en` is low, the store does not change.
- R6: At an active read edge where `rd_en` is low and `rd_rst` is low, `rd_data` holds its previous value.
- R7: A read and a write of the same word on the same clock edge return the value stored before the write.
- R8: The write port acts on the rising edge of `wr_clk` when `WR_RISE` is 1 and on the falling edge when it is 0. The read port does the same with `rd_clk` and `RD_RISE`.
- R9: While `wr_rst` is high at an active write edge, no write takes place even if `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_rst | input | 1 | Synchronous write-domain reset; blocks writes |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8+ASPECT | Write word address |
| wr_data | input | 16>>ASPECT | Write data |
| wr_mask | input | 16 | Per-bit write mask, used in shape 0 only |
| rd_clk | input | 1 | Read port clock |
| rd_rst | input | 1 | Synchronous read-domain reset; clears the output register |
| rd_en | input | 1 | Read enable; loads the output register |
| rd_addr | input | 8+ASPECT | Read word address |
| rd_data | output | 16>>ASPECT | Registered read data |

## Verification
A stored word becomes visible one active write edge after the write is presented. `rd_data` shows a new value one active read edge after the read is presented. The bench drives all inputs two time units after a rising edge, so each set of inputs meets exactly one falling edge and then one rising edge. All outputs are compared one full period after the drive, by which time every read edge, of either polarity, has occurred. For the polarity requirement, an extra sample falls between the falling edge and the next rising edge: read ports on the falling edge must already show the new word there, and read ports on the rising edge must still show the old one. The reference model applies a write ahead of a read only for the instance whose write edge precedes its read edge within a period.

// File: rtl/ar_ram4k_pkg.sv
package ar_ram4k_pkg;

    localparam int STORE_BITS = 4096;
    localparam int ROW_BITS   = 16;
    localparam int ROWS       = STORE_BITS / ROW_BITS;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int COL_W      = $clog2(ROW_BITS);
    localparam int OFF_W      = $clog2(STORE_BITS);
    localparam int MAX_AW     = ROW_AW + COL_W - 1;

    typedef enum logic [1:0] {
        ASPECT_256X16 = 2'd0,
        ASPECT_512X8  = 2'd1,
        ASPECT_1024X4 = 2'd2,
        ASPECT_2048X2 = 2'd3
    } aspect_e;

    typedef struct packed {
        logic                we;
        logic [ROW_AW-1:0]   row;
        logic [ROW_BITS-1:0] msk;
        logic [ROW_BITS-1:0] dat;
    } wr_req_t;

    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [COL_W-1:0]  col;
    } loc_t;

    function automatic int width_log2(aspect_e a);
        return COL_W - int'(a);
    endfunction

    function automatic int data_bits(aspect_e a);
        return ROW_BITS >> int'(a);
    endfunction

    function automatic int addr_bits(aspect_e a);
        return ROW_AW + int'(a);
    endfunction

    function automatic loc_t locate(aspect_e a, logic [MAX_AW-1:0] addr);
        logic [OFF_W-1:0] off;
        loc_t             l;
        off   = OFF_W'(addr) << width_log2(a);
        l.row = off[OFF_W-1:COL_W];
        l.col = off[COL_W-1:0];
        return l;
    endfunction

endpackage

// File: rtl/ar_ram4k_wr_lane.sv
module ar_ram4k_wr_lane
    import ar_ram4k_pkg::*;
#(
    parameter aspect_e ASPECT = ASPECT_256X16,
    localparam int AW = addr_bits(ASPECT),
    localparam int DW = data_bits(ASPECT)
) (
    input  logic                wr_rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [ROW_BITS-1:0] wr_mask,
    output wr_req_t             req
);

    loc_t loc;
    logic we;

    assign loc = locate(ASPECT, MAX_AW'(wr_addr));
    assign we  = wr_en & ~wr_rst;

    generate
        if (ASPECT == ASPECT_256X16) begin : g_wide
            always_comb begin
                req.we  = we;
                req.row = loc.row;
                req.msk = we ? wr_mask : '0;
                req.dat = ROW_BITS'(wr_data);
            end
        end else begin : g_narrow
            logic [ROW_BITS-1:0] lane_bits;
            logic                unused_mask;
            assign lane_bits   = ROW_BITS'((1 << DW) - 1);
            assign unused_mask = ^wr_mask;
            always_comb begin
                req.we  = we;
                req.row = loc.row;
                req.msk = we ? (lane_bits << loc.col) : '0;
                req.dat = {(ROW_BITS / DW){wr_data}};
            end
        end
    endgenerate

endmodule

// File: rtl/ar_ram4k_store.sv
module ar_ram4k_store
    import ar_ram4k_pkg::*;
#(
    parameter aspect_e              ASPECT    = ASPECT_256X16,
    parameter bit                   WR_RISE   = 1'b1,
    parameter logic [STORE_BITS-1:0] INIT_BITS = '0,
    localparam int DW = data_bits(ASPECT)
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  wr_req_t             req,
    input  logic [ROW_AW-1:0]   rd_row,
    output logic [ROW_BITS-1:0] rd_word
);

    logic [ROW_BITS-1:0] mem [ROWS];

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            mem[r] = INIT_BITS[r*ROW_BITS +: ROW_BITS];
        end
    end

    generate
        if (WR_RISE) begin : g_rise
            always_ff @(posedge wr_clk) begin
                if (req.we) begin
                    mem[req.row] <= (mem[req.row] & ~req.msk) | (req.dat & req.msk);
                end
            end
        end else begin : g_fall
            always_ff @(negedge wr_clk) begin
                if (req.we) begin
                    mem[req.row] <= (mem[req.row] & ~req.msk) | (req.dat & req.msk);
                end
            end
        end
    endgenerate

    assign rd_word = mem[rd_row];

    logic act_clk;
    assign act_clk = WR_RISE ? wr_clk : ~wr_clk;

    // R3: enabled bits take the new data
    p_wr_update_r3: assert property (@(posedge act_clk) disable iff (wr_rst)
        req.we |=> ((mem[$past(req.row)] & $past(req.msk)) == ($past(req.dat) & $past(req.msk))))
        else $error("write did not land in enabled bits");

    // R3: disabled bits keep their value
    p_wr_keep_r3: assert property (@(posedge act_clk) disable iff (wr_rst)
        req.we |=> ((mem[$past(req.row)] & ~$past(req.msk)) == ($past(mem[req.row]) & ~$past(req.msk))))
        else $error("write disturbed masked bits");

    // R5: no enable, no change
    p_no_write_r5: assert property (@(posedge act_clk) disable iff (wr_rst)
        !req.we |=> (mem[$past(req.row)] == $past(mem[req.row])))
        else $error("store changed without a write");

    generate
        if (ASPECT != ASPECT_256X16) begin : g_lane_chk
            // R4: a narrow write touches exactly one lane of DW bits
            p_lane_width_r4: assert property (@(posedge act_clk) disable iff (wr_rst)
                $countones(req.msk) == (req.we ? DW : 0))
                else $error("narrow write lane width wrong");
        end
    endgenerate

endmodule

// File: rtl/ar_ram4k_rd_port.sv
module ar_ram4k_rd_port
    import ar_ram4k_pkg::*;
#(
    parameter aspect_e ASPECT  = ASPECT_256X16,
    parameter bit      RD_RISE = 1'b1,
    localparam int AW = addr_bits(ASPECT),
    localparam int DW = data_bits(ASPECT)
) (
    input  logic                rd_clk,
    input  logic                rd_rst,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [ROW_AW-1:0]   rd_row,
    input  logic [ROW_BITS-1:0] rd_word,
    output logic [DW-1:0]       rd_data
);

    loc_t                loc;
    logic [ROW_BITS-1:0] shifted;
    logic [DW-1:0]       field;

    assign loc     = locate(ASPECT, MAX_AW'(rd_addr));
    assign rd_row  = loc.row;
    assign shifted = rd_word >> loc.col;
    assign field   = shifted[DW-1:0];

    generate
        if (RD_RISE) begin : g_rise
            always_ff @(posedge rd_clk) begin
                if (rd_rst) begin
                    rd_data <= '0;
                end else if (rd_en) begin
                    rd_data <= field;
                end
            end
        end else begin : g_fall
            always_ff @(negedge rd_clk) begin
                if (rd_rst) begin
                    rd_data <= '0;
                end else if (rd_en) begin
                    rd_data <= field;
                end
            end
        end
    endgenerate

    logic act_clk;
    assign act_clk = RD_RISE ? rd_clk : ~rd_clk;

    // R6: output register holds while the read is idle
    p_rd_hold_r6: assert property (@(posedge act_clk) disable iff (rd_rst)
        !rd_en |=> $stable(rd_data))
        else $error("read data moved without enable");

    // R2: an enabled read delivers the addressed store lane one edge later
    p_rd_load_r2: assert property (@(posedge act_clk) disable iff (rd_rst)
        rd_en |=> (rd_data == $past(field)))
        else $error("read data does not match addressed lane");

endmodule

// File: rtl/ar_ram4k.sv
module ar_ram4k
    import ar_ram4k_pkg::*;
#(
    parameter aspect_e               ASPECT    = ASPECT_256X16,
    parameter bit                    WR_RISE   = 1'b1,
    parameter bit                    RD_RISE   = 1'b1,
    parameter logic [STORE_BITS-1:0] INIT_BITS = '0,
    localparam int AW = addr_bits(ASPECT),
    localparam int DW = data_bits(ASPECT)
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [ROW_BITS-1:0] wr_mask,
    input  logic                rd_clk,
    input  logic                rd_rst,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    wr_req_t             req;
    logic [ROW_AW-1:0]   rd_row;
    logic [ROW_BITS-1:0] rd_word;

    ar_ram4k_wr_lane #(
        .ASPECT (ASPECT)
    ) u_wr_lane (
        .wr_rst  (wr_rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .req     (req)
    );

    ar_ram4k_store #(
        .ASPECT    (ASPECT),
        .WR_RISE   (WR_RISE),
        .INIT_BITS (INIT_BITS)
    ) u_store (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .req     (req),
        .rd_row  (rd_row),
        .rd_word (rd_word)
    );

    ar_ram4k_rd_port #(
        .ASPECT  (ASPECT),
        .RD_RISE (RD_RISE)
    ) u_rd_port (
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_row  (rd_row),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

endmodule

// File: tb/ar_ram4k_tb_top.sv
module ar_ram4k_tb_top;
    import ar_ram4k_pkg::*;

    localparam int CLK_PERIOD = 10;

    function automatic logic [STORE_BITS-1:0] mk_init();
        logic [STORE_BITS-1:0] v;
        for (int i = 0; i < STORE_BITS; i++) begin
            v[i] = 1'(((i * 37) + ((i >> 3) * 11)) ^ (i >> 5) ^ (i >> 9));
        end
        return v;
    endfunction

    localparam logic [STORE_BITS-1:0] INIT_PAT = mk_init();

    logic        clk = 1'b0;
    logic        wr_rst, rd_rst, wr_en, rd_en;
    logic [10:0] wa, ra;
    logic [15:0] wd, wm;
    logic [15:0] rd0;
    logic [7:0]  rd1;
    logic [3:0]  rd2;
    logic [1:0]  rd3;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // instance 0: 256x16, write rise, read rise
    ar_ram4k #(.ASPECT(ASPECT_256X16), .WR_RISE(1'b1), .RD_RISE(1'b1), .INIT_BITS(INIT_PAT)) dut_i (
        .wr_clk(clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wa[7:0]), .wr_data(wd),
        .wr_mask(wm), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(ra[7:0]), .rd_data(rd0));
    // instance 1: 512x8, write fall, read rise
    ar_ram4k #(.ASPECT(ASPECT_512X8), .WR_RISE(1'b0), .RD_RISE(1'b1), .INIT_BITS(INIT_PAT)) dut1_i (
        .wr_clk(clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wa[8:0]), .wr_data(wd[7:0]),
        .wr_mask(wm), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(ra[8:0]), .rd_data(rd1));
    // instance 2: 1024x4, write rise, read fall
    ar_ram4k #(.ASPECT(ASPECT_1024X4), .WR_RISE(1'b1), .RD_RISE(1'b0), .INIT_BITS(INIT_PAT)) dut2_i (
        .wr_clk(clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wa[9:0]), .wr_data(wd[3:0]),
        .wr_mask(wm), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(ra[9:0]), .rd_data(rd2));
    // instance 3: 2048x2, write fall, read fall
    ar_ram4k #(.ASPECT(ASPECT_2048X2), .WR_RISE(1'b0), .RD_RISE(1'b0), .INIT_BITS(INIT_PAT)) dut3_i (
        .wr_clk(clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wa), .wr_data(wd[1:0]),
        .wr_mask(wm), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(ra), .rd_data(rd3));

    logic [STORE_BITS-1:0] model [4];
    logic [15:0]           expv  [4];
    logic [15:0]           saved [4];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic int dwid(int k);
        return 16 >> k;
    endfunction

    function automatic int amask(int k);
        return (1 << (8 + k)) - 1;
    endfunction

    function automatic logic [15:0] got_of(int k);
        case (k)
            0:       return rd0;
            1:       return {8'h0, rd1};
            2:       return {12'h0, rd2};
            default: return {14'h0, rd3};
        endcase
    endfunction

    task automatic model_write(int k);
        int a;
        a = int'(wa) & amask(k);
        if (wr_en && !wr_rst) begin
            for (int b = 0; b < dwid(k); b++) begin
                if (k != 0 || wm[b]) model[k][a * dwid(k) + b] = wd[b];
            end
        end
    endtask

    task automatic model_read(int k);
        int a;
        a = int'(ra) & amask(k);
        if (rd_rst) begin
            expv[k] = '0;
        end else if (rd_en) begin
            expv[k] = '0;
            for (int b = 0; b < dwid(k); b++) expv[k][b] = model[k][a * dwid(k) + b];
        end
    endtask

    // instance 1 writes on the falling edge before its rising read edge
    task automatic model_cycle();
        for (int k = 0; k < 4; k++) begin
            if (k == 1) begin
                model_write(k);
                model_read(k);
            end else begin
                model_read(k);
                model_write(k);
            end
        end
    endtask

    task automatic step();
        model_cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(int k, string tag, logic [15:0] want);
        checks++;
        if (got_of(k) !== want) begin
            fails++;
            $display("FAIL %s inst %0d actual %h expected %h", tag, k, got_of(k), want);
        end
    endtask

    task automatic chk_all(string tag);
        for (int k = 0; k < 4; k++) chk(k, tag, expv[k]);
    endtask

    task automatic idle();
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic rd_at(logic [10:0] a);
        wr_en = 1'b0;
        rd_en = 1'b1;
        ra    = a;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            model[k] = INIT_PAT;
            expv[k]  = '0;
        end
        wr_rst = 1'b1; rd_rst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b1;
        wa = '0; ra = '0; wd = '0; wm = '0;
        @(posedge clk);
        #2;
        step(); step(); step();
        chk_all("R1 reset clears read data");

        // R9: write during write reset is dropped
        rd_rst = 1'b0;
        wr_en = 1'b1; rd_en = 1'b0; wa = 11'd3; wd = 16'hA5A5; wm = 16'hFFFF;
        step();
        wr_rst = 1'b0;
        rd_at(11'd3);
        chk_all("R9 write blocked by write reset");

        // R2: initial contents at low and top addresses
        rd_at(11'd0);
        chk_all("R2 init word 0");
        rd_at(11'h7FF);
        chk_all("R2 init top word");
        rd_at(11'd77);
        chk_all("R2 init word 77");

        // R6: idle read holds
        rd_en = 1'b0; ra = 11'd200;
        step();
        chk_all("R6 idle read holds");

        // R5: write enable low leaves the store alone
        wr_en = 1'b0; wa = 11'd9; wd = 16'h1234; wm = 16'hFFFF; rd_en = 1'b0;
        step();
        rd_at(11'd9);
        chk_all("R5 no write without enable");

        // R3 / R4: masked write
        wr_en = 1'b1; rd_en = 1'b0; wa = 11'd5; wd = 16'hFFFF; wm = 16'h00F0;
        step();
        wd = 16'h0000; wm = 16'h0F00;
        step();
        rd_at(11'd5);
        chk(0, "R3 masked write mode 0", expv[0]);
        for (int k = 1; k < 4; k++) chk(k, "R4 mask ignored narrow", expv[k]);

        // R7: same word written and read on one edge
        wr_en = 1'b1; rd_en = 1'b1; wa = 11'd40; ra = 11'd40; wd = 16'h5AC3; wm = 16'hFFFF;
        step();
        chk_all("R7 no bypass on same address");
        rd_at(11'd40);
        chk_all("R7 follow-up read shows write");

        // R8: falling-edge readers update before the rising edge
        rd_at(11'd0);
        for (int k = 0; k < 4; k++) saved[k] = expv[k];
        idle();
        rd_en = 1'b1; ra = 11'd123;
        model_cycle();
        @(negedge clk);
        #2;
        chk(0, "R8 rise reader not yet updated", saved[0]);
        chk(1, "R8 rise reader not yet updated", saved[1]);
        chk(2, "R8 fall reader updated", expv[2]);
        chk(3, "R8 fall reader updated", expv[3]);
        @(posedge clk);
        #2;
        chk_all("R8 all readers updated");

        // R1: reset during an enabled read
        rd_rst = 1'b1; rd_en = 1'b1; ra = 11'd7; wr_en = 1'b0;
        step();
        chk_all("R1 reset wins over read enable");
        rd_rst = 1'b0;

        // random traffic, addresses often confined to force collisions (R2 R3 R4 R7)
        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r     = $urandom();
            wr_en = r[0];
            rd_en = r[1] | r[2];
            wm    = 16'($urandom());
            wd    = 16'($urandom());
            if (r[3]) begin
                wa = 11'($urandom() & 32'h1F);
                ra = 11'($urandom() & 32'h1F);
            end else begin
                wa = 11'($urandom());
                ra = 11'($urandom());
            end
            if (r[7:4] == 4'h0) ra = wa;
            step();
            chk_all("R2 random traffic");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule